// File: doc/BRIEF.md
# Network Adapter Control and Parity-Error Capture Registers

This block is the host-facing register set of a network adapter. It holds three 16-bit registers behind a simple word-wide port with a two-bit register select. The first is a control/status word. Its control bits drive the network controller's reset and attention lines, release the transceiver from loopback, enable two interrupt sources, enable an auxiliary memory bus, select the larger memory size and supply four address bits of the RAM base. It also shows two read-only flags. The second is a parity-control word. It reports a captured memory parity error and accepts a write-one acknowledge. The third holds the low 16 bits of the failing address.

Parity events arrive from the memory path as a one-cycle pulse carrying the failing address, the source of the access and the failing byte lane. The first event sets a pending flag and records its details. Later events are dropped while the flag is set, so the record always describes the oldest unacknowledged error. The controller's interrupt request is sampled into a flag. The host interrupt line is formed from the two flags, each gated by its own enable bit. To signal attention, software writes the attention bit to one and then back to zero.

Top module: `adapter_ctrl_regs`

## Requirements
- R1: After reset every register reads 0x0000 and every output, including the host interrupt, is low.
- R2: A write to select 0 stores bits 15, 14, 13, 12, 11, 5, 4 and 3..0, which read back from the next cycle. From that cycle on they drive, in order: the controller reset, transceiver on-air, controller attention, the controller-interrupt enable, the parity-interrupt enable, the auxiliary-bus enable, the large-memory select and the RAM base high nibble.
- R3: In the status word, bit 9 (parity pending) and bit 8 (controller interrupt) are read-only, and bits 10, 7 and 6 always read zero. Writing ones or zeros to any of these five bits changes nothing.
- R4: Status bit 8 shows the controller interrupt input as sampled at the previous clock edge.
- R5: A parity event while none is pending sets status bit 9 in the next cycle. In the same cycle it records the details: the source in parity-word bit 7, the byte lane in bit 6, address bits 19..16 in bits 3..0, and address bits 15..0 in the register at select 2.
- R6: A parity event while one is already pending leaves the pending flag and all recorded fields unchanged.
- R7: A write to select 1 with bit 8 set clears the pending flag. The recorded fields keep their values. Parity-word bit 8 always reads zero, and no other bit of the parity word is writable.
- R8: If an acknowledge and a parity event fall in the same cycle, the new event is recorded and the flag stays set.
- R9: The host interrupt is high exactly when (status bit 8 and bit 12) or (status bit 9 and bit 11).
- R10: Writes to select 2 are ignored, and select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 parity control, 2 failing address low, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ctl_irq_in | input | 1 | Interrupt request level from the controller |
| par_evt | input | 1 | One-cycle parity error event |
| par_src | input | 1 | Source of the failing access |
| par_lane | input | 1 | Byte lane that failed |
| par_addr | input | 20 | Failing address |
| ctl_reset | output | 1 | Controller reset |
| ctl_attn | output | 1 | Controller attention |
| xcvr_onair | output | 1 | Transceiver released from loopback |
| aux_bus_en | output | 1 | Auxiliary memory bus enable |
| mem_large | output | 1 | Larger memory size selected |
| ram_base_hi | output | 4 | RAM base address bits 17..20 |
| host_irq | output | 1 | Combined host interrupt |

## Verification
If the pending flag is held wrongly, it shows on the next status read and on host_irq in the cycle after the event or acknowledge. If the capture gate is wrong, a second event overwrites the recorded fields, and the parity-word or address-low read shows this at once. A wrong write mask in the status word shows in the readback, and in the matching output pin, one cycle after the write. The bench sweeps many status patterns and all sixteen combinations of the interrupt flags and enables to catch such faults.

// File: rtl/adp_pkg.sv
package adp_pkg;
   // Status word bit positions
   localparam int ST_RESET  = 15;
   localparam int ST_ONAIR  = 14;
   localparam int ST_ATTN   = 13;
   localparam int ST_IEN    = 12;
   localparam int ST_PIEN   = 11;
   localparam int ST_PFLAG  = 9;
   localparam int ST_IFLAG  = 8;
   localparam int ST_AUXEN  = 5;
   localparam int ST_BIGMEM = 4;
   // Parity control word bit positions
   localparam int PC_ACK    = 8;
   localparam int PC_SRC    = 7;
   localparam int PC_LANE   = 6;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_PCTL   = 2'd1,
      SEL_ELO    = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic        rst;
      logic        onair;
      logic        attn;
      logic        ien;
      logic        pien;
      logic        auxen;
      logic        bigmem;
      logic [3:0]  base_hi;
   } ctl_fields_t;
endpackage

// File: rtl/adp_ctl_status.sv
module adp_ctl_status
   import adp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output ctl_fields_t       ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_en) begin
         ctl.rst     <= wdata[ST_RESET];
         ctl.onair   <= wdata[ST_ONAIR];
         ctl.attn    <= wdata[ST_ATTN];
         ctl.ien     <= wdata[ST_IEN];
         ctl.pien    <= wdata[ST_PIEN];
         ctl.auxen   <= wdata[ST_AUXEN];
         ctl.bigmem  <= wdata[ST_BIGMEM];
         ctl.base_hi <= wdata[3:0];
      end
   end
endmodule

// File: rtl/adp_par_capture.sv
module adp_par_capture #(
   parameter int HI_W = 4,
   parameter int LO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt,
   input  logic            src,
   input  logic            lane,
   input  logic [HI_W-1:0] addr_hi,
   input  logic [LO_W-1:0] addr_lo,
   input  logic            ack,
   output logic            pending,
   output logic            cap_src,
   output logic            cap_lane,
   output logic [HI_W-1:0] cap_hi,
   output logic [LO_W-1:0] cap_lo
);
   // An acknowledge frees the slot in the same cycle, so a coincident event is kept.
   logic take;
   assign take = evt && (!pending || ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         cap_src  <= 1'b0;
         cap_lane <= 1'b0;
         cap_hi   <= '0;
         cap_lo   <= '0;
      end else begin
         if (take) begin
            pending  <= 1'b1;
            cap_src  <= src;
            cap_lane <= lane;
            cap_hi   <= addr_hi;
            cap_lo   <= addr_lo;
         end else if (ack) begin
            pending  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adp_irq_combine.sv
module adp_irq_combine #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_in,
   input  logic ien,
   input  logic pien,
   input  logic perr,
   output logic irq_flag,
   output logic host_irq
);
   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_flag <= 1'b0;
            else        irq_flag <= irq_in;
         end
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] stages;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stages <= '0;
            else        stages <= {stages[SYNC_STAGES-2:0], irq_in};
         end
         assign irq_flag = stages[SYNC_STAGES-1];
      end
   endgenerate

   assign host_irq = (irq_flag && ien) || (perr && pien);
endmodule

// File: rtl/adapter_ctrl_regs.sv
module adapter_ctrl_regs
   import adp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_HI_W   = 4,
   parameter int ADDR_LO_W   = 16,
   parameter int SYNC_STAGES = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [1:0]                    reg_sel,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic                          ctl_irq_in,
   input  logic                          par_evt,
   input  logic                          par_src,
   input  logic                          par_lane,
   input  logic [ADDR_HI_W+ADDR_LO_W-1:0] par_addr,
   output logic                          ctl_reset,
   output logic                          ctl_attn,
   output logic                          xcvr_onair,
   output logic                          aux_bus_en,
   output logic                          mem_large,
   output logic [ADDR_HI_W-1:0]          ram_base_hi,
   output logic                          host_irq
);
   localparam int ADDR_W = ADDR_HI_W + ADDR_LO_W;

   generate
      if (DATA_W != 16)        begin : g_bad_data  $error("DATA_W must be 16");        end
      if (ADDR_HI_W != 4)      begin : g_bad_hi    $error("ADDR_HI_W must be 4");      end
      if (ADDR_LO_W != DATA_W) begin : g_bad_lo    $error("ADDR_LO_W must equal DATA_W"); end
      if (SYNC_STAGES < 1)     begin : g_bad_sync  $error("SYNC_STAGES must be >= 1"); end
   endgenerate

   reg_sel_e              sel;
   logic                  wr_status, ack;
   ctl_fields_t           ctl;
   logic                  pending, cap_src, cap_lane, irq_flag;
   logic [ADDR_HI_W-1:0]  cap_hi;
   logic [ADDR_LO_W-1:0]  cap_lo;

   assign sel       = reg_sel_e'(reg_sel);
   assign wr_status = reg_wr && (sel == SEL_STATUS);
   assign ack       = reg_wr && (sel == SEL_PCTL) && reg_wdata[PC_ACK];

   adp_ctl_status #(.DATA_W(DATA_W)) i_status (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_status),
      .wdata (reg_wdata),
      .ctl   (ctl)
   );

   adp_par_capture #(.HI_W(ADDR_HI_W), .LO_W(ADDR_LO_W)) i_parity (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (par_evt),
      .src      (par_src),
      .lane     (par_lane),
      .addr_hi  (par_addr[ADDR_W-1:ADDR_LO_W]),
      .addr_lo  (par_addr[ADDR_LO_W-1:0]),
      .ack      (ack),
      .pending  (pending),
      .cap_src  (cap_src),
      .cap_lane (cap_lane),
      .cap_hi   (cap_hi),
      .cap_lo   (cap_lo)
   );

   adp_irq_combine #(.SYNC_STAGES(SYNC_STAGES)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (ctl_irq_in),
      .ien      (ctl.ien),
      .pien     (ctl.pien),
      .perr     (pending),
      .irq_flag (irq_flag),
      .host_irq (host_irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_STATUS: begin
            reg_rdata[ST_RESET]  = ctl.rst;
            reg_rdata[ST_ONAIR]  = ctl.onair;
            reg_rdata[ST_ATTN]   = ctl.attn;
            reg_rdata[ST_IEN]    = ctl.ien;
            reg_rdata[ST_PIEN]   = ctl.pien;
            reg_rdata[ST_PFLAG]  = pending;
            reg_rdata[ST_IFLAG]  = irq_flag;
            reg_rdata[ST_AUXEN]  = ctl.auxen;
            reg_rdata[ST_BIGMEM] = ctl.bigmem;
            reg_rdata[3:0]       = ctl.base_hi;
         end
         SEL_PCTL: begin
            reg_rdata[PC_SRC]  = cap_src;
            reg_rdata[PC_LANE] = cap_lane;
            reg_rdata[3:0]     = cap_hi;
         end
         SEL_ELO:  reg_rdata = cap_lo;
         default:  reg_rdata = '0;
      endcase
   end

   assign ctl_reset   = ctl.rst;
   assign ctl_attn    = ctl.attn;
   assign xcvr_onair  = ctl.onair;
   assign aux_bus_en  = ctl.auxen;
   assign mem_large   = ctl.bigmem;
   assign ram_base_hi = ctl.base_hi;
endmodule

// File: rtl/adp_ctrl_chk.sv
module adp_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [1:0]  reg_sel,
   input logic [15:0] reg_wdata,
   input logic        par_evt,
   input logic        pending,
   input logic        irq_flag,
   input logic        ctl_reset,
   input logic        ien,
   input logic        pien,
   input logic [15:0] cap_lo,
   input logic [3:0]  cap_hi,
   input logic        host_irq
);
   logic ack_c;
   assign ack_c = reg_wr && (reg_sel == 2'd1) && reg_wdata[8];

   a_r2_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd0) |=> (ctl_reset == $past(reg_wdata[15])));

   a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      par_evt |=> pending);

   a_r6_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack_c) |=> ($stable(cap_lo) && $stable(cap_hi) && pending));

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_c && !par_evt) |=> !pending);

   a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> ((irq_flag && ien) || (pending && pien)));

   a_r9_parity_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && pien) |-> host_irq);
endmodule

bind adapter_ctrl_regs adp_ctrl_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .par_evt   (par_evt),
   .pending   (pending),
   .irq_flag  (irq_flag),
   .ctl_reset (ctl_reset),
   .ien       (ctl.ien),
   .pien      (ctl.pien),
   .cap_lo    (cap_lo),
   .cap_hi    (cap_hi),
   .host_irq  (host_irq)
);

// File: tb/test_adapter_ctrl_regs.sv
`timescale 1ns/1ps
module test_adapter_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ctl_irq_in = 1'b0;
   logic        par_evt = 1'b0;
   logic        par_src = 1'b0;
   logic        par_lane = 1'b0;
   logic [19:0] par_addr = '0;
   logic        ctl_reset, ctl_attn, xcvr_onair, aux_bus_en, mem_large, host_irq;
   logic [3:0]  ram_base_hi;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   adapter_ctrl_regs i_adapter_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_irq_in(ctl_irq_in),
      .par_evt(par_evt), .par_src(par_src), .par_lane(par_lane), .par_addr(par_addr),
      .ctl_reset(ctl_reset), .ctl_attn(ctl_attn), .xcvr_onair(xcvr_onair),
      .aux_bus_en(aux_bus_en), .mem_large(mem_large), .ram_base_hi(ram_base_hi),
      .host_irq(host_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Drive after a falling edge, let one rising edge pass, release after the next falling edge.
   task automatic write_reg(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic read_reg(input logic [1:0] s, output logic [15:0] d);
      reg_sel = s;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulse_evt(input logic s, input logic l, input logic [19:0] a);
      @(negedge clk);
      par_evt = 1'b1; par_src = s; par_lane = l; par_addr = a;
      @(negedge clk);
      par_evt = 1'b0;
   endtask

   function automatic logic [15:0] pword(input logic s, input logic l, input logic [19:0] a);
      return {8'h00, s, l, 2'b00, a[19:16]};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] rd;
      logic [19:0] a1, a2, a3;
      a1 = 20'hA1234; a2 = 20'h5BEEF; a3 = 20'h3C0DE;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      read_reg(2'd0, rd); check("R1 status", rd, 16'h0000);
      read_reg(2'd1, rd); check("R1 pctl", rd, 16'h0000);
      read_reg(2'd2, rd); check("R1 elo", rd, 16'h0000);
      check("R1 outputs", {ctl_reset, ctl_attn, xcvr_onair, aux_bus_en, mem_large, ram_base_hi, host_irq}, 0);

      // R2/R3: sweep of status patterns; writable mask 0xF83F
      for (int v = 0; v < 65536; v += 97) begin
         logic [15:0] w;
         w = 16'(v);
         write_reg(2'd0, w);
         read_reg(2'd0, rd);
         check("R2 R3 status readback", rd, w & 16'hF83F);
         check("R2 status outputs", {ctl_reset, xcvr_onair, ctl_attn, aux_bus_en, mem_large, ram_base_hi},
               {w[15], w[14], w[13], w[5], w[4], w[3:0]});
      end
      write_reg(2'd0, 16'hFFFF);
      read_reg(2'd0, rd); check("R3 all ones", rd, 16'hF83F);

      // attention pulse by write one then zero
      write_reg(2'd0, 16'h2000); check("R2 attn high", ctl_attn, 1);
      write_reg(2'd0, 16'h0000); check("R2 attn low", ctl_attn, 0);

      // R4: controller interrupt flag
      @(negedge clk); ctl_irq_in = 1'b1;
      @(negedge clk); read_reg(2'd0, rd); check("R4 flag set", rd[8], 1);
      ctl_irq_in = 1'b0;
      @(negedge clk); read_reg(2'd0, rd); check("R4 flag clear", rd[8], 0);

      // R5: first capture
      pulse_evt(1'b1, 1'b0, a1);
      read_reg(2'd0, rd); check("R5 pending", rd[9], 1);
      read_reg(2'd1, rd); check("R5 pctl", rd, pword(1'b1, 1'b0, a1));
      read_reg(2'd2, rd); check("R5 elo", rd, a1[15:0]);

      // R3: writes to flag bits with a pending error
      write_reg(2'd0, 16'h0000);
      read_reg(2'd0, rd); check("R3 flag survives write", rd, 16'h0200);

      // R6: second event ignored
      pulse_evt(1'b0, 1'b1, a2);
      read_reg(2'd1, rd); check("R6 pctl held", rd, pword(1'b1, 1'b0, a1));
      read_reg(2'd2, rd); check("R6 elo held", rd, a1[15:0]);

      // R7: write without ack bit changes nothing; R10 writes to elo ignored
      write_reg(2'd1, 16'hFEFF);
      read_reg(2'd1, rd); check("R7 no-ack write", rd, pword(1'b1, 1'b0, a1));
      read_reg(2'd0, rd); check("R7 still pending", rd[9], 1);
      write_reg(2'd2, 16'h1357);
      read_reg(2'd2, rd); check("R10 elo write ignored", rd, a1[15:0]);
      read_reg(2'd3, rd); check("R10 sel3 zero", rd, 16'h0000);

      // R7: acknowledge
      write_reg(2'd1, 16'h0100);
      read_reg(2'd0, rd); check("R7 ack clears", rd[9], 0);
      read_reg(2'd1, rd); check("R7 fields kept", rd, pword(1'b1, 1'b0, a1));

      // R5 again with new values
      pulse_evt(1'b0, 1'b1, a2);
      read_reg(2'd1, rd); check("R5 recapture pctl", rd, pword(1'b0, 1'b1, a2));
      read_reg(2'd2, rd); check("R5 recapture elo", rd, a2[15:0]);

      // R8: ack and event together
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0100;
      par_evt = 1'b1; par_src = 1'b1; par_lane = 1'b1; par_addr = a3;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; par_evt = 1'b0;
      read_reg(2'd0, rd); check("R8 pending", rd[9], 1);
      read_reg(2'd1, rd); check("R8 pctl", rd, pword(1'b1, 1'b1, a3));
      read_reg(2'd2, rd); check("R8 elo", rd, a3[15:0]);
      write_reg(2'd1, 16'h0100);

      // R9: all sixteen combinations of flags and enables
      for (int m = 0; m < 16; m++) begin
         logic exp_irq;
         write_reg(2'd0, {3'b000, m[0] ? 1'b1 : 1'b0, m[1] ? 1'b1 : 1'b0, 11'd0});
         ctl_irq_in = m[2];
         if (m[3]) pulse_evt(1'b0, 1'b0, 20'h00001);
         else      write_reg(2'd1, 16'h0100);
         @(negedge clk);
         exp_irq = (m[2] && m[0]) || (m[3] && m[1]);
         check("R9 host_irq", host_irq, exp_irq);
         read_reg(2'd0, rd);
         check("R9 flags", {rd[9], rd[8]}, {m[3] ? 1'b1 : 1'b0, m[2] ? 1'b1 : 1'b0});
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule